// File: doc/BRIEF.md
# Breakpoint Value Register Access Arbiter

This block decides what happens to a system-register read or write aimed at one of the breakpoint value registers. Each access arrives with a strobe, its instruction encoding fields, the current exception level and a set of control and state inputs: which higher exception levels exist, whether the hypervisor level is enabled, the halt state, the secure-debug-disabled flag, the monitor, hypervisor and fine-grained trap controls, the external-debug access trap, the OS lock and a halting-allowed flag. One cycle later the block presents exactly one verdict. The verdict is allow, undefined, trap to EL2, trap to EL3, or halt into debug state. A trap verdict also carries its syndrome class.

The verdict comes from a priority chain, and the chain depends on the exception level. EL0 is always refused. EL1 runs the full chain. EL2 skips the fine-grained and hypervisor stages. EL3 only tests the external-debug halt. A build parameter selects whether the halted, secure-debug-disabled monitor-trap case is raised to the head of the chain at EL1 and EL2. The breakpoint index comes from CRm. An index at or above the number of breakpoints built is refused as undefined. An access whose encoding is not the breakpoint value register pattern produces no verdict.

The block does not perform the register access itself, and it does not take the exception.

Top module: `bkpt_access_arbiter`

## Requirements
- R1: While rstN is low, resValid is 0, resVec is 0, resSyndrome is 0 and resIndex is 0.
- R2: A verdict appears only when accValid is high and the encoding matches the breakpoint value register pattern: op0=2'b10, op1=3'b000, CRn=4'b0000, op2=3'b100 (CRm is free). The verdict is registered and shows on the cycle after the strobe. In every other case, resValid and resVec are 0 on the next cycle.
- R3: When resValid is 1, exactly one bit of resVec is set. The bit meanings are: bit0 allow, bit1 undefined, bit2 trap to EL2, bit3 trap to EL3, bit4 halt. resIndex equals the CRm of that access.
- R4: An access with curEl=0 gives undefined.
- R5: An access whose CRm value is NUM_BKPT or higher gives undefined, at every exception level.
- R6: This rule applies at EL1 and EL2 when EL3_PRIO_HALTED=1. If isHalted, hasEl3, secDbgOff and monTrapDbg are all 1, the verdict is undefined. This check comes before every other EL1/EL2 check.
- R7: At EL1, after R6, the fine-grained stage runs. It is active when hasEl2 and el2Enabled are both 1 and (hasEl3 is 0 or monFgtEnable is 1). It gives trap to EL2 when the bit for the accessed index is set in fgReadTrap (for reads, accWrite=0) or in fgWriteTrap (for writes, accWrite=1).
- R8: At EL1, after R7, the verdict is trap to EL2 when hasEl2 and el2Enabled are both 1 and either hypTrapRoute or hypTrapDbg is 1. At EL2, neither R7 nor R8 applies.
- R9: At EL1 and EL2, after R8, the monitor stage runs when hasEl3 and monTrapDbg are both 1. It gives undefined when isHalted and secDbgOff are both 1, and trap to EL3 otherwise.
- R10: If no earlier stage decides (at EL1, EL2 or EL3), the verdict is halt when osLocked=0, haltAllowed=1 and extTrapDbg=1, and allow otherwise. At EL3 no trap verdict occurs.
- R11: resSyndrome is 6'h18 for a trap-to-EL2 or trap-to-EL3 verdict, and 0 for every other verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access strobe |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accOp0 | input | 2 | Encoding op0 |
| accOp1 | input | 3 | Encoding op1 |
| accCrn | input | 4 | Encoding CRn |
| accCrm | input | 4 | Encoding CRm, the breakpoint index |
| accOp2 | input | 3 | Encoding op2 |
| curEl | input | 2 | Current exception level, 0 to 3 |
| isHalted | input | 1 | Core is in debug state |
| hasEl2 | input | 1 | EL2 is implemented |
| hasEl3 | input | 1 | EL3 is implemented |
| el2Enabled | input | 1 | EL2 is enabled in the current security state |
| secDbgOff | input | 1 | Secure debug is disabled |
| monFgtEnable | input | 1 | Monitor enable for fine-grained traps |
| monTrapDbg | input | 1 | Monitor trap of debug register accesses |
| hypTrapRoute | input | 1 | Hypervisor routing of debug exceptions |
| hypTrapDbg | input | 1 | Hypervisor trap of debug register accesses |
| fgReadTrap | input | NUM_BKPT | Fine-grained read trap, one bit per breakpoint |
| fgWriteTrap | input | NUM_BKPT | Fine-grained write trap, one bit per breakpoint |
| extTrapDbg | input | 1 | External-debug trap of register accesses |
| osLocked | input | 1 | OS lock is set |
| haltAllowed | input | 1 | Halting is allowed |
| resValid | output | 1 | Verdict is present |
| resVec | output | 5 | One-hot verdict |
| resSyndrome | output | 6 | Syndrome class for traps |
| resIndex | output | 4 | Breakpoint index of the verdict |

## Verification
The bench builds the arbiter with NUM_BKPT=6 and EL3_PRIO_HALTED=1. The smaller breakpoint count makes the unimplemented indices 6 to 15 reachable, so the undefined verdict for missing breakpoints is exercised. Setting the priority option to 1 lets the bench show that a halted, secure-debug-disabled monitor trap wins over a fine-grained trap, which the other setting would allow. The bench runs directed cases, one for each priority stage, followed by randomized control patterns. It checks every cycle against an independent behavioural model.

// File: rtl/bkpt_arb_pkg.sv
package bkpt_arb_pkg;

  localparam int RES_W   = 5;
  localparam int IDX_W   = 4;
  localparam int IDX_SPAN = 1 << IDX_W;
  localparam int SYN_W   = 6;

  localparam logic [SYN_W-1:0] TRAP_SYNDROME = 6'h18;

  localparam logic [1:0] ENC_OP0 = 2'b10;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0000;
  localparam logic [2:0] ENC_OP2 = 3'b100;

  typedef enum logic [2:0] {
    RES_ALLOW = 3'd0,
    RES_UNDEF = 3'd1,
    RES_TRAP2 = 3'd2,
    RES_TRAP3 = 3'd3,
    RES_HALT  = 3'd4
  } resKind_e;

  typedef struct packed {
    logic             load;
    logic [RES_W-1:0] onehot;
    logic             trap;
    logic [IDX_W-1:0] idx;
  } arbStrobe_t;

endpackage

// File: rtl/bkpt_access_decode.sv
module bkpt_access_decode
  import bkpt_arb_pkg::*;
(
  input  logic [1:0] accOp0,
  input  logic [2:0] accOp1,
  input  logic [3:0] accCrn,
  input  logic [2:0] accOp2,
  output logic       encHit
);

  logic op0Ok;
  logic op1Ok;
  logic crnOk;
  logic op2Ok;

  always_comb begin
    op0Ok  = (accOp0 == ENC_OP0);
    op1Ok  = (accOp1 == ENC_OP1);
    crnOk  = (accCrn == ENC_CRN);
    op2Ok  = (accOp2 == ENC_OP2);
    encHit = op0Ok & op1Ok & crnOk & op2Ok;
  end

endmodule

// File: rtl/bkpt_access_ctrl.sv
module bkpt_access_ctrl
  import bkpt_arb_pkg::*;
#(
  parameter int NUM_BKPT        = 16,
  parameter bit EL3_PRIO_HALTED = 1'b1
) (
  input  logic                accValid,
  input  logic                encHit,
  input  logic                accWrite,
  input  logic [IDX_W-1:0]    accCrm,
  input  logic [1:0]          curEl,
  input  logic                isHalted,
  input  logic                hasEl2,
  input  logic                hasEl3,
  input  logic                el2Enabled,
  input  logic                secDbgOff,
  input  logic                monFgtEnable,
  input  logic                monTrapDbg,
  input  logic                hypTrapRoute,
  input  logic                hypTrapDbg,
  input  logic [NUM_BKPT-1:0] fgReadTrap,
  input  logic [NUM_BKPT-1:0] fgWriteTrap,
  input  logic                extTrapDbg,
  input  logic                osLocked,
  input  logic                haltAllowed,
  output arbStrobe_t          strobe
);

  localparam logic [IDX_W:0] BKPT_LIMIT = (IDX_W+1)'(NUM_BKPT);

  logic [IDX_SPAN-1:0] rdTrapWide;
  logic [IDX_SPAN-1:0] wrTrapWide;

  generate
    if (NUM_BKPT < IDX_SPAN) begin : g_pad
      assign rdTrapWide = {{(IDX_SPAN-NUM_BKPT){1'b0}}, fgReadTrap};
      assign wrTrapWide = {{(IDX_SPAN-NUM_BKPT){1'b0}}, fgWriteTrap};
    end else begin : g_full
      assign rdTrapWide = fgReadTrap;
      assign wrTrapWide = fgWriteTrap;
    end
  endgenerate

  logic     implemented;
  logic     el2Live;
  logic     fgGate;
  logic     fgBit;
  logic     haltHit;
  logic     earlyUndef;
  logic     hypHit;
  logic     monHit;
  logic     lowerEl;
  resKind_e kind;

  always_comb begin
    implemented = ({1'b0, accCrm} < BKPT_LIMIT);
    el2Live     = hasEl2 & el2Enabled;
    fgGate      = el2Live & (~hasEl3 | monFgtEnable);
    fgBit       = accWrite ? wrTrapWide[accCrm] : rdTrapWide[accCrm];
    hypHit      = el2Live & (hypTrapRoute | hypTrapDbg);
    monHit      = hasEl3 & monTrapDbg;
    haltHit     = ~osLocked & haltAllowed & extTrapDbg;
    earlyUndef  = EL3_PRIO_HALTED & isHalted & hasEl3 & secDbgOff & monTrapDbg;
    lowerEl     = (curEl == 2'd1);

    if (!implemented || curEl == 2'd0) begin
      kind = RES_UNDEF;
    end else if (curEl == 2'd3) begin
      kind = haltHit ? RES_HALT : RES_ALLOW;
    end else if (earlyUndef) begin
      kind = RES_UNDEF;
    end else if (lowerEl && fgGate && fgBit) begin
      kind = RES_TRAP2;
    end else if (lowerEl && hypHit) begin
      kind = RES_TRAP2;
    end else if (monHit) begin
      kind = (isHalted && secDbgOff) ? RES_UNDEF : RES_TRAP3;
    end else if (haltHit) begin
      kind = RES_HALT;
    end else begin
      kind = RES_ALLOW;
    end

    strobe.load   = accValid & encHit;
    strobe.onehot = RES_W'(1) << kind;
    strobe.trap   = (kind == RES_TRAP2) || (kind == RES_TRAP3);
    strobe.idx    = accCrm;
  end

endmodule

// File: rtl/bkpt_access_dpath.sv
module bkpt_access_dpath
  import bkpt_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strobe,
  output logic             resValid,
  output logic [RES_W-1:0] resVec,
  output logic [SYN_W-1:0] resSyndrome,
  output logic [IDX_W-1:0] resIndex
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid    <= 1'b0;
      resVec      <= '0;
      resSyndrome <= '0;
      resIndex    <= '0;
    end else begin
      resValid    <= strobe.load;
      resVec      <= strobe.load ? strobe.onehot : '0;
      resSyndrome <= (strobe.load && strobe.trap) ? TRAP_SYNDROME : '0;
      resIndex    <= strobe.load ? strobe.idx : '0;
    end
  end

endmodule

// File: rtl/bkpt_access_arbiter.sv
module bkpt_access_arbiter
  import bkpt_arb_pkg::*;
#(
  parameter int NUM_BKPT        = 16,
  parameter bit EL3_PRIO_HALTED = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                accValid,
  input  logic                accWrite,
  input  logic [1:0]          accOp0,
  input  logic [2:0]          accOp1,
  input  logic [3:0]          accCrn,
  input  logic [3:0]          accCrm,
  input  logic [2:0]          accOp2,
  input  logic [1:0]          curEl,
  input  logic                isHalted,
  input  logic                hasEl2,
  input  logic                hasEl3,
  input  logic                el2Enabled,
  input  logic                secDbgOff,
  input  logic                monFgtEnable,
  input  logic                monTrapDbg,
  input  logic                hypTrapRoute,
  input  logic                hypTrapDbg,
  input  logic [NUM_BKPT-1:0] fgReadTrap,
  input  logic [NUM_BKPT-1:0] fgWriteTrap,
  input  logic                extTrapDbg,
  input  logic                osLocked,
  input  logic                haltAllowed,
  output logic                resValid,
  output logic [4:0]          resVec,
  output logic [5:0]          resSyndrome,
  output logic [3:0]          resIndex
);

  logic       encHit;
  arbStrobe_t strobe;

  bkpt_access_decode u_decode (
    .accOp0 (accOp0),
    .accOp1 (accOp1),
    .accCrn (accCrn),
    .accOp2 (accOp2),
    .encHit (encHit)
  );

  bkpt_access_ctrl #(
    .NUM_BKPT        (NUM_BKPT),
    .EL3_PRIO_HALTED (EL3_PRIO_HALTED)
  ) u_ctrl (
    .accValid     (accValid),
    .encHit       (encHit),
    .accWrite     (accWrite),
    .accCrm       (accCrm),
    .curEl        (curEl),
    .isHalted     (isHalted),
    .hasEl2       (hasEl2),
    .hasEl3       (hasEl3),
    .el2Enabled   (el2Enabled),
    .secDbgOff    (secDbgOff),
    .monFgtEnable (monFgtEnable),
    .monTrapDbg   (monTrapDbg),
    .hypTrapRoute (hypTrapRoute),
    .hypTrapDbg   (hypTrapDbg),
    .fgReadTrap   (fgReadTrap),
    .fgWriteTrap  (fgWriteTrap),
    .extTrapDbg   (extTrapDbg),
    .osLocked     (osLocked),
    .haltAllowed  (haltAllowed),
    .strobe       (strobe)
  );

  bkpt_access_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .resValid    (resValid),
    .resVec      (resVec),
    .resSyndrome (resSyndrome),
    .resIndex    (resIndex)
  );

endmodule

// File: rtl/bkpt_access_arbiter_chk.sv
module bkpt_access_arbiter_chk #(
  parameter int NUM_BKPT = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       accValid,
  input logic [1:0] accOp0,
  input logic [2:0] accOp1,
  input logic [3:0] accCrn,
  input logic [3:0] accCrm,
  input logic [2:0] accOp2,
  input logic [1:0] curEl,
  input logic       resValid,
  input logic [4:0] resVec,
  input logic [5:0] resSyndrome
);

  logic patternOk;
  logic idxOk;
  assign patternOk = (accOp0 == 2'b10) && (accOp1 == 3'b000) &&
                     (accCrn == 4'b0000) && (accOp2 == 3'b100);
  assign idxOk = ({1'b0, accCrm} < 5'(NUM_BKPT));

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> ($countones(resVec) == 1)); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resValid |-> (resVec == 5'b0)); // R2

  AST_NO_STROBE_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && patternOk) |=> !resValid); // R2

  AST_EL0_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && patternOk && curEl == 2'd0) |=> (resVec == 5'b00010)); // R4

  AST_MISSING_BKPT: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && patternOk && !idxOk) |=> (resVec == 5'b00010)); // R5

  AST_EL3_NO_TRAP: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && patternOk && curEl == 2'd3) |=> (resVec[2] == 1'b0 && resVec[3] == 1'b0)); // R10

  AST_TRAP_SYNDROME: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && (resVec[2] || resVec[3])) |-> (resSyndrome == 6'h18)); // R11

  AST_PLAIN_SYNDROME: assert property (@(posedge clk) disable iff (!rstN)
    !(resVec[2] || resVec[3]) |-> (resSyndrome == 6'h0)); // R11

endmodule

bind bkpt_access_arbiter bkpt_access_arbiter_chk #(.NUM_BKPT(NUM_BKPT)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .accValid    (accValid),
  .accOp0      (accOp0),
  .accOp1      (accOp1),
  .accCrn      (accCrn),
  .accCrm      (accCrm),
  .accOp2      (accOp2),
  .curEl       (curEl),
  .resValid    (resValid),
  .resVec      (resVec),
  .resSyndrome (resSyndrome)
);

// File: tb/bkpt_access_arbiter_bench.sv
module bkpt_access_arbiter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB         = 6;
  localparam bit PRIO       = 1'b1;

  logic clk = 1'b0;
  logic rstN;
  logic accValid, accWrite;
  logic [1:0] accOp0;
  logic [2:0] accOp1;
  logic [3:0] accCrn, accCrm;
  logic [2:0] accOp2;
  logic [1:0] curEl;
  logic isHalted, hasEl2, hasEl3, el2Enabled, secDbgOff, monFgtEnable;
  logic monTrapDbg, hypTrapRoute, hypTrapDbg, extTrapDbg, osLocked, haltAllowed;
  logic [NB-1:0] fgReadTrap, fgWriteTrap;
  logic resValid;
  logic [4:0] resVec;
  logic [5:0] resSyndrome;
  logic [3:0] resIndex;

  int checks = 0;
  int errors = 0;

  logic       expValid;
  logic [4:0] expVec;
  logic [5:0] expSyn;
  logic [3:0] expIdx;
  string      expTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_access_arbiter #(.NUM_BKPT(NB), .EL3_PRIO_HALTED(PRIO)) u_bkpt_access_arbiter (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accOp0(accOp0), .accOp1(accOp1), .accCrn(accCrn), .accCrm(accCrm), .accOp2(accOp2),
    .curEl(curEl), .isHalted(isHalted), .hasEl2(hasEl2), .hasEl3(hasEl3),
    .el2Enabled(el2Enabled), .secDbgOff(secDbgOff), .monFgtEnable(monFgtEnable),
    .monTrapDbg(monTrapDbg), .hypTrapRoute(hypTrapRoute), .hypTrapDbg(hypTrapDbg),
    .fgReadTrap(fgReadTrap), .fgWriteTrap(fgWriteTrap), .extTrapDbg(extTrapDbg),
    .osLocked(osLocked), .haltAllowed(haltAllowed),
    .resValid(resValid), .resVec(resVec), .resSyndrome(resSyndrome), .resIndex(resIndex)
  );

  // Verdict numbers: 0 allow, 1 undefined, 2 trap EL2, 3 trap EL3, 4 halt
  function automatic int judge(output string tag);
    int el;
    bit ownEl2, fgOn, trapBit, haltOk;
    el      = int'(curEl);
    ownEl2  = hasEl2 && el2Enabled;
    haltOk  = !osLocked && haltAllowed && extTrapDbg;
    tag = "R4";
    if (el == 0) return 1;
    tag = "R5";
    if (int'(accCrm) >= NB) return 1;
    if (el == 3) begin
      tag = "R10";
      return haltOk ? 4 : 0;
    end
    tag = "R6";
    if (PRIO && isHalted && hasEl3 && secDbgOff && monTrapDbg) return 1;
    if (el == 1) begin
      fgOn    = ownEl2 && (!hasEl3 || monFgtEnable);
      trapBit = accWrite ? fgWriteTrap[accCrm] : fgReadTrap[accCrm];
      tag = "R7";
      if (fgOn && trapBit) return 2;
      tag = "R8";
      if (ownEl2 && (hypTrapRoute || hypTrapDbg)) return 2;
    end
    tag = "R9";
    if (hasEl3 && monTrapDbg) return (isHalted && secDbgOff) ? 1 : 3;
    tag = "R10";
    return haltOk ? 4 : 0;
  endfunction

  task automatic compareNow();
    checks++;
    if (resValid !== expValid || resVec !== expVec || resSyndrome !== expSyn ||
        resIndex !== expIdx) begin
      errors++;
      $display("FAIL %s: got valid=%0b vec=%05b syn=%0h idx=%0d, expected valid=%0b vec=%05b syn=%0h idx=%0d",
               expTag, resValid, resVec, resSyndrome, resIndex,
               expValid, expVec, expSyn, expIdx);
    end
  endtask

  // Inputs already set at a falling edge; verdict is checked one cycle later
  task automatic advance();
    int v;
    string t;
    bit hit;
    hit = accValid && accOp0 == 2'b10 && accOp1 == 3'b000 && accCrn == 4'b0000 &&
          accOp2 == 3'b100;
    if (hit) begin
      v = judge(t);
      expValid = 1'b1;
      expVec   = 5'(1 << v);
      expSyn   = (v == 2 || v == 3) ? 6'h18 : 6'h00;
      expIdx   = accCrm;
      expTag   = {t, "/R3/R11"};
    end else begin
      expValid = 1'b0;
      expVec   = '0;
      expSyn   = '0;
      expIdx   = '0;
      expTag   = "R2";
    end
    @(negedge clk);
    compareNow();
  endtask

  task automatic quiet();
    accValid = 1'b0; accWrite = 1'b0;
    accOp0 = 2'b10; accOp1 = 3'b000; accCrn = 4'b0000; accOp2 = 3'b100; accCrm = 4'd0;
    curEl = 2'd1; isHalted = 1'b0; hasEl2 = 1'b1; hasEl3 = 1'b1; el2Enabled = 1'b1;
    secDbgOff = 1'b0; monFgtEnable = 1'b1; monTrapDbg = 1'b0; hypTrapRoute = 1'b0;
    hypTrapDbg = 1'b0; extTrapDbg = 1'b0; osLocked = 1'b0; haltAllowed = 1'b0;
    fgReadTrap = '0; fgWriteTrap = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    quiet();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expValid = 0; expVec = 0; expSyn = 0; expIdx = 0; expTag = "R1";
    compareNow();
    rstN = 1'b1;
    advance();

    // R4 EL0 refused
    quiet(); accValid = 1; curEl = 2'd0; accCrm = 4'd1; advance();
    // R5 missing breakpoint at EL3 and EL1
    quiet(); accValid = 1; curEl = 2'd3; accCrm = 4'd7; advance();
    quiet(); accValid = 1; curEl = 2'd1; accCrm = 4'd15; advance();
    // R10 plain allow at EL1
    quiet(); accValid = 1; accCrm = 4'd5; advance();
    // R7 read trap bit, EL3 absent
    quiet(); accValid = 1; hasEl3 = 0; monFgtEnable = 0; accCrm = 4'd2;
    fgReadTrap = 6'b000100; advance();
    // R7 write ignores read trap bit -> allow
    accWrite = 1; advance();
    // R7 write trap bit
    fgWriteTrap = 6'b000100; advance();
    // R7 gate closed by monitor enable -> allow
    quiet(); accValid = 1; monFgtEnable = 0; accCrm = 4'd2; fgReadTrap = 6'b000100; advance();
    // R8 hypervisor trap at EL1, skipped at EL2
    quiet(); accValid = 1; hypTrapDbg = 1; advance();
    quiet(); accValid = 1; hypTrapRoute = 1; curEl = 2'd2; advance();
    // R8 with EL2 disabled -> allow
    quiet(); accValid = 1; hypTrapDbg = 1; el2Enabled = 0; advance();
    // R9 monitor trap at EL1 and EL2
    quiet(); accValid = 1; monTrapDbg = 1; advance();
    quiet(); accValid = 1; monTrapDbg = 1; curEl = 2'd2; accCrm = 4'd3; advance();
    // R9 halted without secure-debug-off still traps
    quiet(); accValid = 1; monTrapDbg = 1; isHalted = 1; advance();
    // R6 halted secure-debug-off beats fine-grained trap
    quiet(); accValid = 1; monTrapDbg = 1; isHalted = 1; secDbgOff = 1;
    fgReadTrap = 6'b000001; advance();
    // R10 halt at EL3 and EL1, OS lock blocks it
    quiet(); accValid = 1; curEl = 2'd3; extTrapDbg = 1; haltAllowed = 1; monTrapDbg = 1; advance();
    osLocked = 1; advance();
    quiet(); accValid = 1; extTrapDbg = 1; haltAllowed = 1; advance();
    // R2 bad encoding and no strobe
    quiet(); accValid = 1; accOp2 = 3'b101; advance();
    quiet(); accValid = 1; accCrn = 4'b0001; advance();
    quiet(); accValid = 0; curEl = 2'd0; advance();

    // Randomized patterns
    for (int i = 0; i < 4000; i++) begin
      accValid = ($urandom_range(7) != 0);
      accWrite = 1'($urandom);
      accOp0 = 2'b10; accOp1 = 3'b000; accCrn = 4'b0000; accOp2 = 3'b100;
      if ($urandom_range(9) == 0) accOp1 = 3'($urandom);
      if ($urandom_range(9) == 0) accOp2 = 3'($urandom);
      accCrm = ($urandom_range(3) == 0) ? 4'($urandom) : 4'($urandom_range(NB-1));
      curEl = 2'($urandom);
      isHalted = 1'($urandom); hasEl2 = ($urandom_range(3) != 0);
      hasEl3 = 1'($urandom); el2Enabled = ($urandom_range(3) != 0);
      secDbgOff = 1'($urandom); monFgtEnable = 1'($urandom);
      monTrapDbg = ($urandom_range(3) == 0); hypTrapRoute = ($urandom_range(3) == 0);
      hypTrapDbg = ($urandom_range(3) == 0); extTrapDbg = 1'($urandom);
      osLocked = 1'($urandom); haltAllowed = 1'($urandom);
      fgReadTrap = NB'($urandom) & NB'($urandom);
      fgWriteTrap = NB'($urandom) & NB'($urandom);
      advance();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule